// File: doc/BRIEF.md
# Dual-Clock Elastic Sample Buffer

This block carries a continuous sample stream from one clock to another, where the two clocks come from a common source and keep a fixed phase relationship. A typical pair is 368.64 MHz for writing and 245.76 MHz for reading. Over time the writer stores as many words as the reader consumes. Storage is a 16-word dual-port memory. The write port and the read port each own an address counter that runs only in its own clock. No address value and no fill flag ever crosses between the clocks.

The writer stores each word presented with its valid high. When its counter first reaches the half-depth mark, it raises a sticky start flag. That flag is the only signal that crosses domains, through a two-flop synchronizer. Once the reader sees it, the reader reads one word on every read clock, without pause and without an occupancy check, and drives an output valid that stays high from then on.

A dedicated reset input, local to this buffer, clears both counters and the start state. It is meant to be pulsed just before each capture, so that every capture begins from a clean half-full alignment. The reset is asserted asynchronously in each domain and released synchronously to each clock.

Top module: `elastic_buf`

## Requirements
- R1: Words leave on rd_data in exactly the order they were accepted, with none lost or repeated, across any number of wraps of the 16-entry storage (both 4-bit address counters wrap from 15 to 0).
- R2: A word is stored only on a wr_clk edge where wr_valid is 1; data presented while wr_valid is 0 never appears on rd_data and does not advance the write address.
- R3: After reset, rd_valid stays 0 until at least 8 words (half of the 16-word depth) have been accepted; with fewer accepted, it stays 0 indefinitely.
- R4: Once rd_valid has become 1, it stays 1 on every rd_clk cycle until the next reset.
- R5: The first word with rd_valid = 1 after a reset is the first word accepted after that reset.
- R6: While buf_rst is 1, rd_valid is 0, whatever the state was before; after buf_rst returns to 0, the buffer behaves as freshly empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| buf_rst | input | 1 | Reset dedicated to this buffer, active high, asynchronous assertion |
| wr_clk | input | 1 | Write clock |
| wr_valid | input | 1 | wr_data holds a word to store on this edge |
| wr_data | input | WIDTH (16) | Write word |
| rd_clk | input | 1 | Read clock, phase-locked to wr_clk |
| rd_valid | output | 1 | rd_data holds a stream word; 1 on every cycle after start |
| rd_data | output | WIDTH (16) | Read word |

## Verification
The bench streams sequences that wrap the storage many times, with wr_valid gated to two out of three write clocks so that the rates match. It fills the idle cycles with junk data, so a design that stores on every edge would show corrupted words. Some streams stall just below the half-full mark for a long time. A reader that started early, or that started on a synchronizer that had not cleared, would raise rd_valid with fewer than 8 words stored. Every run is preceded by a reset that lands while the previous stream is still running. A design whose reset failed to clear the read counter or the start flag would continue the old stream, or skip ahead, instead of restarting at the first new word. A reader that paused, or dropped valid after it had started, would break the unbroken run of valid words.

// File: rtl/elastic_pkg.sv
package elastic_pkg;

    // read side: waiting for the half-full start, or streaming
    typedef enum logic {
        RD_WAIT = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_e;

endpackage

// File: rtl/eb_sync.sv
// Multi-stage synchronizer with asynchronous assertion of its reset value.
// As a reset synchronizer: d tied low, RESET_VAL high.
// As a level synchronizer: d is the crossing bit, RESET_VAL low.
module eb_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) sh_q <= {STAGES{RESET_VAL}};
        else      sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];

endmodule

// File: rtl/eb_dpram.sv
// Simple dual-port memory: write port on wclk, registered read port on rclk.
module eb_dpram #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rclk,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (re) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/eb_wr_side.sv
// Write address counter and sticky half-full start flag (write domain).
module eb_wr_side #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          start
);

    localparam int HALF = DEPTH / 2;

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          start;
    } wr_st_t;

    wr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (in_valid) st_d.ptr = st_q.ptr + 1'b1;
        // ptr equals HALF for the first time only after HALF accepted words
        if (st_q.ptr == AW'(HALF)) st_d.start = 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wr_en   = in_valid;
    assign wr_addr = st_q.ptr;
    assign start   = st_q.start;

    // R2
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (st_q.ptr == $past(st_q.ptr)));

    // R3
    start_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.start |=> st_q.start);

endmodule

// File: rtl/eb_rd_side.sv
// Read address counter: waits for the synchronized start, then reads every cycle.
module eb_rd_side
    import elastic_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_in,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          out_valid
);

    typedef struct packed {
        rd_state_e     state;
        logic [AW-1:0] ptr;
        logic          valid;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        rd_en = 1'b0;
        case (st_q.state)
            RD_WAIT: begin
                if (start_in) st_d.state = RD_RUN;
            end
            RD_RUN: begin
                rd_en      = 1'b1;
                st_d.ptr   = st_q.ptr + 1'b1;
                st_d.valid = 1'b1;
            end
            default: st_d.state = RD_WAIT;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '{state: RD_WAIT, ptr: '0, valid: 1'b0};
        else     st_q <= st_d;
    end

    assign rd_addr   = st_q.ptr;
    assign out_valid = st_q.valid;

    // R4
    rd_keep_valid_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.valid |=> st_q.valid);

    // R1
    rd_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.state == RD_RUN) |=> (st_q.ptr == AW'($past(st_q.ptr) + 1'b1)));

    // R3
    rd_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.valid |-> $past(start_in, 2));

endmodule

// File: rtl/elastic_buf.sv
// Dual-clock elastic buffer for phase-locked clocks with equal average rates.
module elastic_buf #(
    parameter int WIDTH       = 16,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             buf_rst,
    input  logic             wr_clk,
    input  logic             wr_valid,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_clk,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data
);

    localparam int AW = $clog2(DEPTH);

    logic          wr_rst, rd_rst;
    logic          wr_en, rd_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic          wr_start, rd_start;

    eb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_wr_rst (
        .clk(wr_clk), .arst(buf_rst), .d(1'b0), .q(wr_rst)
    );

    eb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rd_rst (
        .clk(rd_clk), .arst(buf_rst), .d(1'b0), .q(rd_rst)
    );

    eb_wr_side #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .in_valid(wr_valid),
        .wr_en(wr_en), .wr_addr(wr_addr), .start(wr_start)
    );

    // the only signal crossing from the write clock to the read clock
    eb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_start_sync (
        .clk(rd_clk), .arst(rd_rst), .d(wr_start), .q(rd_start)
    );

    eb_rd_side #(.AW(AW)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .start_in(rd_start),
        .rd_en(rd_en), .rd_addr(rd_addr), .out_valid(rd_valid)
    );

    eb_dpram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wclk(wr_clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
        .rclk(rd_clk), .re(rd_en), .raddr(rd_addr), .rdata(rd_data)
    );

endmodule

// File: tb/sim_elastic_buf.sv
module sim_elastic_buf;

    localparam int WR_PERIOD = 4;   // 3:2 clock ratio, fixed phase
    localparam int RD_PERIOD = 6;
    localparam int HALF      = 8;
    localparam int WATCHDOG  = 100000;

    // base[63:48] step[47:32] nreads[31:16] pause_at[15:8] pause_len[7:0]
    localparam logic [63:0] VEC [6] = '{
        {16'h0000, 16'h0001, 16'd40,  8'd0, 8'd0},
        {16'h1000, 16'h0003, 16'd64,  8'd7, 8'd200},
        {16'hFFF0, 16'h0001, 16'd50,  8'd3, 8'd20},
        {16'h5A5A, 16'h0101, 16'd100, 8'd0, 8'd0},
        {16'h0001, 16'h8000, 16'd33,  8'd5, 8'd9},
        {16'h7777, 16'hFFFF, 16'd48,  8'd1, 8'd100}
    };

    logic        buf_rst = 1'b1;
    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_valid;
    logic [15:0] rd_data;

    int n_chk = 0, n_bad = 0, wr_count = 0, rd_cycles = 0;
    bit stop = 0;

    always #(WR_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2) rd_clk = ~rd_clk;

    elastic_buf u0 (
        .buf_rst(buf_rst), .wr_clk(wr_clk), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_clk(rd_clk), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // R6: reset lands on whatever state is present, output valid must drop
    task automatic apply_reset();
        @(negedge rd_clk);
        buf_rst  = 1'b1;
        wr_valid = 1'b0;
        repeat (2) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R6", int'(rd_valid), 0);
        repeat (3) @(negedge rd_clk);
        buf_rst = 1'b0;
        repeat (6) @(negedge wr_clk);
    endtask

    task automatic run_vec(input logic [15:0] base, input logic [15:0] step,
                           input int nreads, input int pause_at, input int pause_len);
        apply_reset();
        stop     = 0;
        wr_count = 0;
        fork
            begin : wr_proc
                int idx = 0;
                int k   = 0;
                int pl  = pause_len;
                while (!stop) begin
                    @(negedge wr_clk);
                    if (idx == pause_at && pl > 0) begin
                        wr_valid = 1'b0;
                        pl--;
                    end else if (k % 3 != 2) begin
                        wr_valid = 1'b1;
                        wr_data  = base + 16'(idx) * step;
                        idx++;
                    end else begin
                        wr_valid = 1'b0;
                    end
                    if (!wr_valid) wr_data = 16'hDEAD ^ 16'(k);   // R2: junk when idle
                    k++;
                    @(posedge wr_clk);
                    if (wr_valid) wr_count++;
                end
                wr_valid = 1'b0;
            end
            begin : rd_proc
                int got   = 0;
                int waitc = 0;
                bit started = 0;
                while (got < nreads) begin
                    @(negedge rd_clk);
                    if (!started) begin
                        if (rd_valid) begin
                            started = 1;
                            // R3: no output before half the depth was accepted
                            check(wr_count >= HALF, "R3", wr_count, HALF);
                        end else begin
                            waitc++;
                            if (waitc > 2000) begin
                                check(1'b0, "R3 start timeout", 0, 1);
                                break;
                            end
                        end
                    end
                    if (started) begin
                        check(rd_valid == 1'b1, "R4", int'(rd_valid), 1);
                        // R5 for the first word after reset, R1 and R2 for the rest
                        check(rd_data == 16'(base + 16'(got) * step),
                              (got == 0) ? "R5" : "R1/R2",
                              int'(rd_data), int'(16'(base + 16'(got) * step)));
                        got++;
                    end
                end
                stop = 1;
            end
        join
    endtask

    initial begin : watchdog
        forever begin
            @(posedge rd_clk);
            rd_cycles++;
            if (rd_cycles > WATCHDOG) begin
                check(1'b0, "watchdog", rd_cycles, WATCHDOG);
                summary();
            end
        end
    end

    initial begin : main
        // R6: reset state at power-up
        repeat (3) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R6", int'(rd_valid), 0);

        for (int v = 0; v < 6; v++) begin
            run_vec(VEC[v][63:48], VEC[v][47:32], int'(VEC[v][31:16]),
                    int'(VEC[v][15:8]), int'(VEC[v][7:0]));
        end

        // R3: no words written at all, output never becomes valid
        begin
            bit saw = 0;
            apply_reset();
            for (int i = 0; i < 200; i++) begin
                @(negedge rd_clk);
                if (rd_valid) saw = 1;
            end
            check(!saw, "R3", int'(saw), 0);
        end

        // R3: seven words then a long stall, still no output
        begin
            bit saw = 0;
            apply_reset();
            for (int i = 0; i < 7; i++) begin
                @(negedge wr_clk);
                wr_valid = 1'b1;
                wr_data  = 16'(16'h0300 + i);
            end
            @(negedge wr_clk);
            wr_valid = 1'b0;
            for (int i = 0; i < 300; i++) begin
                @(negedge rd_clk);
                if (rd_valid) saw = 1;
            end
            check(!saw, "R3", int'(saw), 0);
        end

        // R6 then R5: a reset of a stalled buffer and a fresh stream restarts at word 0
        run_vec(16'hC000, 16'h0007, 24, 0, 0);

        summary();
    end

endmodule